// File: doc/BRIEF.md
# Sideband Claim-Line Bus Arbiter

This block decides whether the local controller may drive a shared two-wire bus that several controllers can reach. It does not use bit-level arbitration on the bus wires. Instead, every controller owns one open-drain claim line. A line is active low and sits high through a pull-up when nobody drives it. Local logic raises a level request. The arbiter then drives its own claim line low and waits a slew interval so the other controllers can see it. After that it looks at their claim lines. If all of them are idle, it grants the bus. If any of them is asserted, it keeps its claim for one retry interval and looks again. If the lines are still busy, it releases its claim, waits another retry interval, and starts over.

All three intervals are counted in microseconds. The microsecond tick comes from the system clock divided by a parameter. The slew, retry and give-up lengths come in on input ports and are captured when a request is accepted. If the give-up time runs out before a grant, the arbiter releases its claim and raises a one-cycle error pulse instead of a grant. Dropping the request releases the bus at once, whether the arbiter holds a grant or is still trying.

Top module: `bus_claim_arbiter`

## Requirements
- R1: After reset, `claim_n_o` is 1, `grant_o` is 0 and `err_o` is 0.
- R2: An accepted request drives `claim_n_o` low at the first clock edge after `req_i` is seen high. The three lengths are captured at that edge, so later changes to the length inputs do not affect the current attempt.
- R3: Let S be the captured slew length. S*CLK_PER_US cycles after acceptance, if no peer claim line reads low, `grant_o` goes to 1 while `claim_n_o` stays 0. `grant_o` is never 1 while `claim_n_o` is 1.
- R4: If a peer line reads low when the slew interval ends, the claim stays low for R*CLK_PER_US cycles, where R is the retry length. If every peer line is then high, `grant_o` rises at the end of that wait.
- R5: If a peer line is still low at the end of that wait, `claim_n_o` goes to 1 for R*CLK_PER_US cycles. It then goes low again and a new slew interval starts.
- R6: Let G be the captured give-up length. If no grant has been given G*CLK_PER_US cycles after acceptance, the arbiter releases its claim and pulses `err_o` high for exactly one cycle, with no grant. This give-up wins over any slew or retry interval that ends on the same edge.
- R7: When `req_i` is seen low while the arbiter is granted or still trying, `claim_n_o` is 1 and `grant_o` is 0 after that same edge.
- R8: A request is accepted only after `req_i` has been seen low on at least one edge since reset or since the last give-up. A request held high across those events does not claim.
- R9: Each peer claim line passes through a two-flop synchroniser. Any one of the N_PEERS lines reading low counts as contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Level request for the bus from local logic |
| slew_len_i | input | CNT_W | Slew interval in microseconds |
| retry_len_i | input | CNT_W | Retry and back-off interval in microseconds |
| giveup_len_i | input | CNT_W | Give-up time in microseconds |
| peer_claim_n_i | input | N_PEERS | Active-low claim lines of the other controllers |
| claim_n_o | output | 1 | Active-low claim line of this controller |
| grant_o | output | 1 | Bus granted to local logic |
| err_o | output | 1 | One-cycle pulse when the attempt gives up |

## Verification
The hardest case to reach is a give-up that lands on the same edge as the end of a retry wait. The stimulus holds one peer line low through every check and picks a give-up length equal to the tick at which the second contention wait ends. The bench then expects the error pulse and a released claim on that edge, not a back-off phase. A second run sets the give-up time shorter than the slew interval. This shows the give-up also cuts off a slew phase that has not yet finished.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SLEW    = 3'd1,
    ST_HOLD    = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_GRANT   = 3'd4
  } arb_state_t;
endpackage

// File: rtl/claim_sync.sv
module claim_sync #(
  parameter int N_LINES = 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [N_LINES-1:0] line_n_i,
  output logic [N_LINES-1:0] line_n_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic meta_q, sync_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= line_n_i[g];
        sync_q <= meta_q;
      end
    end
    assign line_n_o[g] = sync_q;
  end
endmodule

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int CLK_PER_US = 250
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = en_i && (pre_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) pre_q <= '0;
    else if (en_i)      pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign done_o   = tick_i && (cnt_next >= {1'b0, len_i});

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bus_claim_arbiter.sv
module bus_claim_arbiter
  import arb_pkg::*;
#(
  parameter int N_PEERS    = 1,
  parameter int CLK_PER_US = 250,
  parameter int CNT_W      = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               req_i,
  input  logic [CNT_W-1:0]   slew_len_i,
  input  logic [CNT_W-1:0]   retry_len_i,
  input  logic [CNT_W-1:0]   giveup_len_i,
  input  logic [N_PEERS-1:0] peer_claim_n_i,
  output logic               claim_n_o,
  output logic               grant_o,
  output logic               err_o
);
  arb_state_t         state_q;
  logic [CNT_W-1:0]   slew_q, retry_q, giveup_q;
  logic [CNT_W-1:0]   phase_len;
  logic [N_PEERS-1:0] peer_sync_n;
  logic               armed_q, active, start, tick;
  logic               phase_done, giveup_done, peer_busy;

  claim_sync #(.N_LINES(N_PEERS)) u_sync (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .line_n_i (peer_claim_n_i),
    .line_n_o (peer_sync_n)
  );

  assign peer_busy = ~&peer_sync_n;
  assign active    = (state_q == ST_SLEW) || (state_q == ST_HOLD) ||
                     (state_q == ST_BACKOFF);
  assign start     = (state_q == ST_IDLE) && req_i && armed_q;
  assign phase_len = (state_q == ST_SLEW) ? slew_q : retry_q;

  us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (start),
    .en_i   (active),
    .tick_o (tick)
  );

  tick_timer #(.CNT_W(CNT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (start || phase_done),
    .tick_i (tick),
    .len_i  (phase_len),
    .done_o (phase_done)
  );

  tick_timer #(.CNT_W(CNT_W)) u_giveup (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (start),
    .tick_i (tick),
    .len_i  (giveup_q),
    .done_o (giveup_done)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      claim_n_o <= 1'b1;
      grant_o   <= 1'b0;
      err_o     <= 1'b0;
      armed_q   <= 1'b0;
      slew_q    <= '0;
      retry_q   <= '0;
      giveup_q  <= '0;
    end else begin
      err_o <= 1'b0;
      if (!req_i) armed_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_SLEW;
            claim_n_o <= 1'b0;
            armed_q   <= 1'b0;
            slew_q    <= slew_len_i;
            retry_q   <= retry_len_i;
            giveup_q  <= giveup_len_i;
          end
        end
        ST_SLEW, ST_HOLD, ST_BACKOFF: begin
          if (!req_i) begin
            state_q   <= ST_IDLE;
            claim_n_o <= 1'b1;
          end else if (giveup_done) begin
            state_q   <= ST_IDLE;
            claim_n_o <= 1'b1;
            err_o     <= 1'b1;
          end else if (phase_done) begin
            if (state_q == ST_BACKOFF) begin
              state_q   <= ST_SLEW;
              claim_n_o <= 1'b0;
            end else if (!peer_busy) begin
              state_q <= ST_GRANT;
              grant_o <= 1'b1;
            end else if (state_q == ST_SLEW) begin
              state_q <= ST_HOLD;
            end else begin
              state_q   <= ST_BACKOFF;
              claim_n_o <= 1'b1;
            end
          end
        end
        ST_GRANT: begin
          if (!req_i) begin
            state_q   <= ST_IDLE;
            claim_n_o <= 1'b1;
            grant_o   <= 1'b0;
          end
        end
        default: begin
          state_q   <= ST_IDLE;
          claim_n_o <= 1'b1;
          grant_o   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk_i,
  input logic rst_i,
  input logic req_i,
  input logic claim_n_o,
  input logic grant_o,
  input logic err_o
);
  // R3: a grant is only ever held together with an asserted claim
  p_grant_holds_claim_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_o |-> !claim_n_o);

  // R6: the error indication lasts one cycle
  p_err_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> !err_o);

  // R6: giving up leaves the claim released and no grant
  p_err_released_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (claim_n_o && !grant_o));

  // R7: a low request releases everything on the next cycle
  p_drop_releases_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_i |=> (claim_n_o && !grant_o));

  // R2: the claim is only taken in answer to a request
  p_claim_needs_req_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(claim_n_o) |-> $past(req_i));
endmodule

bind bus_claim_arbiter arb_checker u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .req_i     (req_i),
  .claim_n_o (claim_n_o),
  .grant_o   (grant_o),
  .err_o     (err_o)
);

// File: tb/bus_claim_arbiter_tb.sv
module bus_claim_arbiter_tb;
  localparam int NP = 2;
  localparam int C  = 4;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b1;
  logic [W-1:0]  slew_len = 16'd2, retry_len = 16'd5, giveup_len = 16'd19;
  logic [NP-1:0] peers = '1;
  logic          claim_n, grant, err;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    logic  claim_n;
    logic  grant;
    logic  err;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_claim_arbiter #(.N_PEERS(NP), .CLK_PER_US(C), .CNT_W(W)) u_dut (
    .clk_i          (clk),
    .rst_i          (rst),
    .req_i          (req),
    .slew_len_i     (slew_len),
    .retry_len_i    (retry_len),
    .giveup_len_i   (giveup_len),
    .peer_claim_n_i (peers),
    .claim_n_o      (claim_n),
    .grant_o        (grant),
    .err_o          (err)
  );

  task automatic expect_at(input int at, input logic c, input logic g,
                           input logic e, input string tag);
    exp_t x;
    x.at = at; x.claim_n = c; x.grant = g; x.err = e; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares outputs against scheduled expectations
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t x;
      x = sb_q.pop_front();
      n_checks++;
      if (x.at < cyc) begin
        n_errors++;
        $display("FAIL %s: check missed at cycle %0d (now %0d), expected %b%b%b",
                 x.tag, x.at, cyc, x.claim_n, x.grant, x.err);
      end else if (claim_n !== x.claim_n || grant !== x.grant || err !== x.err) begin
        n_errors++;
        $display("FAIL %s @%0d: claim_n/grant/err actual %b/%b/%b expected %b/%b/%b",
                 x.tag, cyc, claim_n, grant, err, x.claim_n, x.grant, x.err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int a;
    // R1 / R8: reset with request already high
    wait_cyc(5);
    rst = 1'b0;
    expect_at(6, 1'b1, 1'b0, 1'b0, "R1 reset state");
    expect_at(20, 1'b1, 1'b0, 1'b0, "R8 no claim without prior low request");
    drain();
    req = 1'b0;
    wait_cyc(cyc + 3);

    // R2 R3 R7: uncontested claim and release
    req = 1'b1; a = cyc + 1;
    expect_at(a, 1'b0, 1'b0, 1'b0, "R2 claim on accept");
    expect_at(a + 2*C - 1, 1'b0, 1'b0, 1'b0, "R3 no grant before slew end");
    expect_at(a + 2*C, 1'b0, 1'b1, 1'b0, "R3 grant after slew");
    drain();
    wait_cyc(cyc + 5);
    req = 1'b0;
    expect_at(cyc + 1, 1'b1, 1'b0, 1'b0, "R7 release from grant");
    drain();
    wait_cyc(cyc + 3);

    // R4 R9: peer 0 busy, freed during the hold wait
    peers = 2'b10;
    wait_cyc(cyc + 5);
    req = 1'b1; a = cyc + 1;
    expect_at(a + 2*C, 1'b0, 1'b0, 1'b0, "R9 peer0 low blocks grant");
    expect_at(a + 7*C - 1, 1'b0, 1'b0, 1'b0, "R4 claim held during wait");
    expect_at(a + 7*C, 1'b0, 1'b1, 1'b0, "R4 grant after peer freed");
    wait_cyc(a + 4*C);
    peers = 2'b11;
    drain();
    req = 1'b0;
    wait_cyc(cyc + 3);

    // R5 R6: peer 1 stuck, give-up coincides with wait end
    peers = 2'b01;
    wait_cyc(cyc + 5);
    req = 1'b1; a = cyc + 1;
    expect_at(a + 7*C, 1'b1, 1'b0, 1'b0, "R5 back-off releases claim");
    expect_at(a + 12*C - 1, 1'b1, 1'b0, 1'b0, "R5 released through back-off");
    expect_at(a + 12*C, 1'b0, 1'b0, 1'b0, "R5 reclaim after back-off");
    expect_at(a + 19*C - 1, 1'b0, 1'b0, 1'b0, "R6 still holding before give-up");
    expect_at(a + 19*C, 1'b1, 1'b0, 1'b1, "R6 give-up wins over wait end");
    expect_at(a + 19*C + 1, 1'b1, 1'b0, 1'b0, "R6 error is one cycle");
    expect_at(a + 19*C + 40, 1'b1, 1'b0, 1'b0, "R8 no re-claim after give-up");
    drain();

    // R8 R2: re-arm with low request, captured lengths
    req = 1'b0; peers = 2'b11; slew_len = 16'd3;
    wait_cyc(cyc + 4);
    req = 1'b1; a = cyc + 1;
    expect_at(a, 1'b0, 1'b0, 1'b0, "R8 accepted after low request");
    expect_at(a + 3*C - 1, 1'b0, 1'b0, 1'b0, "R2 captured slew not yet over");
    expect_at(a + 3*C, 1'b0, 1'b1, 1'b0, "R2 grant uses captured slew");
    wait_cyc(a + 1);
    slew_len = 16'd50;
    drain();
    req = 1'b0;
    wait_cyc(cyc + 3);

    // R7: abort while holding against a busy peer
    slew_len = 16'd2;
    peers = 2'b10;
    wait_cyc(cyc + 5);
    req = 1'b1; a = cyc + 1;
    wait_cyc(a + 4*C);
    req = 1'b0;
    expect_at(cyc + 1, 1'b1, 1'b0, 1'b0, "R7 abort releases claim");
    drain();
    req = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b0, 1'b0, "R8 re-request after abort claims");
    drain();
    req = 1'b0; peers = 2'b11;
    wait_cyc(cyc + 3);

    // R6: give-up shorter than slew
    slew_len = 16'd5; giveup_len = 16'd3;
    req = 1'b1; a = cyc + 1;
    expect_at(a + 3*C - 1, 1'b0, 1'b0, 1'b0, "R6 slew in progress");
    expect_at(a + 3*C, 1'b1, 1'b0, 1'b1, "R6 give-up cuts slew");
    expect_at(a + 3*C + 1, 1'b1, 1'b0, 1'b0, "R6 error cleared");
    expect_at(a + 5*C + 2, 1'b1, 1'b0, 1'b0, "R6 no late grant");
    drain();
    req = 1'b0;
    wait_cyc(cyc + 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule